// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings a flat panel up in a fixed order of power stages. A step request either runs the whole chain through to the end or attempts a single stage advance. The chain has six action stages: initialisation, then raising the panel supply, then releasing the LVDS transmitter from shutdown, then raising the backlight supply, then starting the backlight PWM, then asserting the backlight enable. Each action is followed by a settling time taken from a millisecond delay table. Time is kept by counting an external microsecond tick. The deadline test uses a signed difference, so a wrapping time counter does no harm.

Each of the four enable lines has a presence flag. An absent line stays low, but its stage still runs and still waits out its delay. The PWM stage emits a one-cycle start strobe. The fixed PWM settings (frequency, divider, duty code) are presented alongside the strobe for a separate PWM generator to use. A failure flag that is seen when the first stage runs stops the chain, and only reset clears that condition.

Top module: `panel_pwr_seq`

## Requirements
- R1: The stage code `stage_o` advances only by +1 per step, through 0 (initial), 1 (panel supply next), 2 (LVDS next), 3 (backlight supply next), 4 (PWM next), 5 (backlight enable next), 6 (finished).
- R2: After the stage with code k runs, where k < NUM_DLY, the next stage runs no sooner than `dly_ms[k]`×US_PER_MS ticks later, and never in the same cycle. Stages with code k ≥ NUM_DLY add no wait. Entry k occupies bits [k*DLY_W +: DLY_W].
- R3: The initial stage runs on the clock edge that samples the step request, with no wait.
- R4: `present` bit 0 gates the panel supply, bit 1 the LVDS release, bit 2 the backlight supply and bit 3 the backlight enable. An absent line stays low, and its stage still takes its full delay.
- R5: In single-step mode (`run_all`=0), a step that arrives before the current deadline leaves the stage unchanged.
- R6: A step with `run_all`=1 keeps advancing, one stage per expired deadline, until code 6 is reached.
- R7: The PWM stage produces exactly one single-cycle `pwm_start` pulse. `pwm_duty` reads 0xDF, `pwm_div` reads 1 and `pwm_freq_hz` reads 32768.
- R8: Once code 6 is reached, further steps in either mode change neither the stage nor any enable.
- R9: If `fail_in` is high when the initial stage would run, `seq_err` rises and the stage stays at 0. All enables stay low and every later step is ignored until reset.
- R10: Deadlines are met correctly when the microsecond counter wraps between the start of a wait and its end.
- R11: While in reset and after reset, all enables, `pwm_start`, `busy`, `done` and `seq_err` are low, and `stage_o` is 0.
- R12: `busy` is high exactly for codes 1 to 5, `done` is high exactly for code 6, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Step request, sampled each cycle |
| run_all | input | 1 | 1: run to completion; 0: single attempt |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| fail_in | input | 1 | Initialisation failure indication |
| dly_ms | input | NUM_DLY*DLY_W | Settling delay per stage, in ms |
| present | input | 4 | Presence flag per enable line |
| panel_vdd_en | output | 1 | Panel supply enable |
| lvds_on | output | 1 | LVDS transmitter shutdown released |
| bl_vdd_en | output | 1 | Backlight supply enable |
| bl_en | output | 1 | Backlight enable |
| pwm_start | output | 1 | One-cycle PWM start strobe |
| pwm_duty | output | DUTY_W | PWM duty code |
| pwm_div | output | DUTY_W | PWM clock divider |
| pwm_freq_hz | output | FREQ_W | PWM frequency in Hz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| seq_err | output | 1 | Sequence aborted at the initial stage |
| stage_o | output | 3 | Current stage code |

## Verification
The bench builds the block with a 9-bit microsecond counter, 4-bit delay entries and 10 ticks per millisecond, with a tick on every cycle. A delay entry therefore becomes an exact cycle count. Every stage's arrival can be predicted from the sum of the gaps, each gap being max(entry×10, 1). The sweep covers 81 delay tables built from the values 0, 1 and 3, together with all sixteen presence masks. Before each start it waits an idle time that grows from run to run, so the 512-count counter wraps in the middle of many waits. Directed runs cover the single-step boundary one cycle before and at the deadline, and the abort at the initial stage.

// File: rtl/pps_pkg.sv
// Package: shared stage encoding for the panel power-up sequencer.
// Assumes: stage codes are consecutive, because the stage register increments.
package pps_pkg;
    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_PANEL = 3'd1,
        ST_LVDS  = 3'd2,
        ST_BLVDD = 3'd3,
        ST_PWM   = 3'd4,
        ST_BLEN  = 3'd5,
        ST_DONE  = 3'd6
    } pps_stage_e;
endpackage

// File: rtl/pps_timebase.sv
// Module: pps_timebase
// Keeps a free-running microsecond count and the deadline for the next stage.
// When a stage runs, the deadline is loaded with now + delay[stage]*US_PER_MS.
// Stages whose index is NUM_DLY or above add no delay.
// Assumes: the longest delay is below half the counter range, so the signed
// difference stays valid across a wrap.
module pps_timebase #(
    parameter int TB_W      = 32,
    parameter int DLY_W     = 10,
    parameter int NUM_DLY   = 4,
    parameter int US_PER_MS = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     us_tick,
    input  logic                     load,
    input  logic [2:0]               stage_idx,
    input  logic [NUM_DLY*DLY_W-1:0] dly_ms,
    output logic                     ready
);
    logic [TB_W-1:0]  now_q;
    logic [TB_W-1:0]  deadline_q;
    logic [DLY_W-1:0] sel_ms;
    logic [TB_W-1:0]  wait_us;
    logic [TB_W-1:0]  diff;

    // Pick the delay entry of the stage that is running now.
    always_comb begin
        sel_ms = '0;
        for (int i = 0; i < NUM_DLY; i++) begin
            if (stage_idx == 3'(i)) sel_ms = dly_ms[i*DLY_W +: DLY_W];
        end
    end

    assign wait_us = TB_W'(sel_ms) * TB_W'(US_PER_MS);
    assign diff    = deadline_q - now_q;
    // The deadline has passed when the signed difference is zero or negative.
    assign ready   = diff[TB_W-1] | (diff == '0);

    // Advance the microsecond count on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       now_q <= '0;
        else if (us_tick) now_q <= now_q + 1'b1;
    end

    // Record the next allowed time when a stage runs.
    always_ff @(posedge clk) begin
        if (!rst_n)    deadline_q <= '0;
        else if (load) deadline_q <= now_q + wait_us;
    end
endmodule

// File: rtl/pps_stage_fsm.sv
// Module: pps_stage_fsm
// Holds the stage register and decides in which cycle a stage runs.
// A step in run-to-end mode sets a running flag that retries every cycle.
// A failure seen at the initial stage latches the error and freezes the chain.
// Assumes: ready comes from pps_timebase and reflects the registered deadline.
module pps_stage_fsm
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       run_all,
    input  logic       ready,
    input  logic       fail_in,
    output pps_stage_e stage,
    output logic       exec,
    output logic       err
);
    logic running;
    logic active;
    logic fail;

    // Work out whether this cycle runs a stage, fails, or does nothing.
    always_comb begin
        active = (step | running) & ~err & (stage != ST_DONE);
        fail   = active & (stage == ST_INIT) & fail_in;
        exec   = active & ~fail & ((stage == ST_INIT) | ready);
    end

    // Stage register: move on by one each time a stage runs.
    always_ff @(posedge clk) begin
        if (!rst_n)    stage <= ST_INIT;
        else if (exec) stage <= pps_stage_e'(stage + 3'd1);
    end

    // Run-to-end flag: set by a step in that mode, cleared at the end or on failure.
    always_ff @(posedge clk) begin
        if (!rst_n)                          running <= 1'b0;
        else if (fail)                       running <= 1'b0;
        else if (exec && stage == ST_BLEN)   running <= 1'b0;
        else if (step && run_all && !err && stage != ST_DONE) running <= 1'b1;
    end

    // Error latch: only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    err <= 1'b0;
        else if (fail) err <= 1'b1;
    end
endmodule

// File: rtl/pps_outputs.sv
// Module: pps_outputs
// Drives the enable lines and the PWM start strobe from stage runs.
// Each line is owned by one stage and copies its presence flag when that
// stage runs. The strobe is high for one cycle after the PWM stage.
// Assumes: each stage runs at most once between resets.
module pps_outputs
    import pps_pkg::*;
#(
    parameter int N_EN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec,
    input  pps_stage_e      stage,
    input  logic [N_EN-1:0] present,
    output logic [N_EN-1:0] en,
    output logic            pwm_start
);
    // Map each enable line to the stage that drives it.
    function automatic pps_stage_e owner(input int idx);
        case (idx)
            0:       return ST_PANEL;
            1:       return ST_LVDS;
            2:       return ST_BLVDD;
            default: return ST_BLEN;
        endcase
    endfunction

    for (genvar g = 0; g < N_EN; g++) begin : g_en
        // Latch the presence flag when the owning stage runs.
        always_ff @(posedge clk) begin
            if (!rst_n)                          en[g] <= 1'b0;
            else if (exec && stage == owner(g))  en[g] <= present[g];
        end
    end

    // Pulse once when the PWM stage runs.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_start <= 1'b0;
        else        pwm_start <= exec && (stage == ST_PWM);
    end
endmodule

// File: rtl/panel_pwr_seq.sv
// Module: panel_pwr_seq (top)
// Staged power-up controller for a flat panel: stage control, deadline
// timing and output drive, plus the fixed PWM settings shown to a PWM block.
// Assumes: us_tick is a single-cycle pulse, and all inputs are synchronous to clk.
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int TB_W      = 32,
    parameter int DLY_W     = 10,
    parameter int NUM_DLY   = 4,
    parameter int US_PER_MS = 1000,
    parameter int DUTY_W    = 8,
    parameter int FREQ_W    = 16,
    parameter int PWM_DUTY  = 8'hDF,
    parameter int PWM_DIV   = 1,
    parameter int PWM_FREQ  = 32768
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     run_all,
    input  logic                     us_tick,
    input  logic                     fail_in,
    input  logic [NUM_DLY*DLY_W-1:0] dly_ms,
    input  logic [3:0]               present,
    output logic                     panel_vdd_en,
    output logic                     lvds_on,
    output logic                     bl_vdd_en,
    output logic                     bl_en,
    output logic                     pwm_start,
    output logic [DUTY_W-1:0]        pwm_duty,
    output logic [DUTY_W-1:0]        pwm_div,
    output logic [FREQ_W-1:0]        pwm_freq_hz,
    output logic                     busy,
    output logic                     done,
    output logic                     seq_err,
    output logic [2:0]               stage_o
);
    localparam int N_EN = 4;

    pps_stage_e      stage;
    logic            exec;
    logic            ready;
    logic [N_EN-1:0] en;

    pps_timebase #(
        .TB_W(TB_W), .DLY_W(DLY_W), .NUM_DLY(NUM_DLY), .US_PER_MS(US_PER_MS)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .load(exec),
        .stage_idx(3'(stage)), .dly_ms(dly_ms), .ready(ready)
    );

    pps_stage_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .step(step), .run_all(run_all),
        .ready(ready), .fail_in(fail_in), .stage(stage), .exec(exec),
        .err(seq_err)
    );

    pps_outputs #(.N_EN(N_EN)) u_out (
        .clk(clk), .rst_n(rst_n), .exec(exec), .stage(stage),
        .present(present), .en(en), .pwm_start(pwm_start)
    );

    assign panel_vdd_en = en[0];
    assign lvds_on      = en[1];
    assign bl_vdd_en    = en[2];
    assign bl_en        = en[3];
    assign pwm_duty     = DUTY_W'(PWM_DUTY);
    assign pwm_div      = DUTY_W'(PWM_DIV);
    assign pwm_freq_hz  = FREQ_W'(PWM_FREQ);
    assign stage_o      = 3'(stage);
    assign done         = (stage == ST_DONE);
    assign busy         = (stage != ST_INIT) && (stage != ST_DONE);
endmodule

// File: rtl/pps_checker.sv
// Module: pps_checker
// Temporal checks on the sequencer's ports, bound into every panel_pwr_seq.
module pps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       panel_vdd_en,
    input logic       lvds_on,
    input logic       bl_vdd_en,
    input logic       bl_en,
    input logic       pwm_start,
    input logic       busy,
    input logic       done,
    input logic       seq_err,
    input logic [2:0] stage_o
);
    // R1
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o != $past(stage_o)) |-> (stage_o == $past(stage_o) + 3'd1));

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (!panel_vdd_en && !lvds_on && !bl_vdd_en && !bl_en
                     && !pwm_start && stage_o == 3'd0));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable({panel_vdd_en, lvds_on, bl_vdd_en, bl_en})));

    // R7
    pwm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_start |=> !pwm_start);

    // R12
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4
    panel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_vdd_en) |-> (stage_o == 3'd2));

    // R4
    blen_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_en) |-> done);
endmodule

bind panel_pwr_seq pps_checker u_pps_chk (
    .clk(clk), .rst_n(rst_n), .panel_vdd_en(panel_vdd_en), .lvds_on(lvds_on),
    .bl_vdd_en(bl_vdd_en), .bl_en(bl_en), .pwm_start(pwm_start),
    .busy(busy), .done(done), .seq_err(seq_err), .stage_o(stage_o)
);

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;
    localparam int TB_W = 9, DLY_W = 4, NUM_DLY = 4, UPM = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, step = 1'b0, run_all = 1'b0, us_tick = 1'b1, fail_in = 1'b0;
    logic [NUM_DLY*DLY_W-1:0] dly_ms = '0;
    logic [3:0] present = '0;
    logic panel_vdd_en, lvds_on, bl_vdd_en, bl_en, pwm_start, busy, done, seq_err;
    logic [7:0] pwm_duty, pwm_div;
    logic [15:0] pwm_freq_hz;
    logic [2:0] stage_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    panel_pwr_seq #(.TB_W(TB_W), .DLY_W(DLY_W), .NUM_DLY(NUM_DLY), .US_PER_MS(UPM)) dut (
        .clk(clk), .rst_n(rst_n), .step(step), .run_all(run_all), .us_tick(us_tick),
        .fail_in(fail_in), .dly_ms(dly_ms), .present(present),
        .panel_vdd_en(panel_vdd_en), .lvds_on(lvds_on), .bl_vdd_en(bl_vdd_en),
        .bl_en(bl_en), .pwm_start(pwm_start), .pwm_duty(pwm_duty), .pwm_div(pwm_div),
        .pwm_freq_hz(pwm_freq_hz), .busy(busy), .done(done), .seq_err(seq_err),
        .stage_o(stage_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step = 1'b0; fail_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int outs();
        return {28'd0, bl_en, bl_vdd_en, lvds_on, panel_vdd_en};
    endfunction

    // Run one blocking sequence and check the arrival cycle of every stage.
    task automatic run_blocking(input int d[4], input logic [3:0] pres, input int idle);
        int expt[7];
        int seen[7];
        int pulses = 0;
        int acc = 0;
        dly_ms = {4'(d[3]), 4'(d[2]), 4'(d[1]), 4'(d[0])};
        present = pres;
        do_reset();
        repeat (idle) @(negedge clk);
        expt[1] = 0;
        for (int k = 1; k < 6; k++) begin
            acc += (k - 1 < NUM_DLY) ? ((d[k-1] * UPM > 1) ? d[k-1] * UPM : 1) : 1;
            expt[k+1] = acc;
        end
        for (int k = 0; k < 7; k++) seen[k] = -1;
        run_all = 1'b1; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (seen[stage_o] < 0) seen[stage_o] = c;
            if (pwm_start) pulses++;
            if (done) break;
            @(negedge clk);
        end
        // R3 the initial stage runs on the step edge
        chk("R3 first stage cycle", seen[1], 0);
        // R2 R6 R10 arrival cycles
        for (int k = 2; k < 7; k++) chk("R2/R6/R10 stage arrival", seen[k], expt[k]);
        chk("R4 enables follow presence", outs(), int'(pres));
        chk("R7 pwm strobe count", pulses, 1);
        chk("R12 busy low at end", int'(busy), 0);
        // R8 further steps have no effect
        step = 1'b1; run_all = 1'b0;
        @(negedge clk);
        run_all = 1'b1;
        @(negedge clk);
        step = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 stage held at end", int'(stage_o), 6);
        chk("R8 enables held at end", outs(), int'(pres));
    endtask

    initial begin
        int vals[3] = '{0, 1, 3};
        int d[4];
        // R11 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 reset stage", int'(stage_o), 0);
        chk("R11 reset outputs", int'({pwm_start, busy, done, seq_err}) + outs(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", int'({pwm_start, busy, done, seq_err, stage_o}) + outs(), 0);
        // R7 fixed PWM settings
        chk("R7 duty", int'(pwm_duty), 8'hDF);
        chk("R7 divider", int'(pwm_div), 1);
        chk("R7 frequency", int'(pwm_freq_hz), 32768);

        // R2 R4 R6 R10 sweep
        for (int i = 0; i < 81; i++) begin
            int r = i;
            for (int j = 0; j < 4; j++) begin d[j] = vals[r % 3]; r = r / 3; end
            run_blocking(d, 4'(i), (i * 13) % 500);
        end

        // R5 single-step timing around the deadline
        dly_ms = {4'd0, 4'd1, 4'd0, 4'd2};
        present = 4'hF; run_all = 1'b0;
        do_reset();
        step = 1'b1;
        @(negedge clk);
        chk("R3 single step runs first stage", int'(stage_o), 1);
        chk("R12 busy during sequence", int'(busy), 1);
        @(negedge clk);
        chk("R5 early step ignored", int'(stage_o), 1);
        step = 1'b0;
        repeat (16) @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 step one cycle before deadline", int'(stage_o), 1);
        @(negedge clk);
        chk("R2 step at deadline advances", int'(stage_o), 2);
        chk("R4 panel supply up", int'(panel_vdd_en), 1);
        @(negedge clk);
        step = 1'b0;
        chk("R2 zero delay gives next cycle", int'(stage_o), 3);
        chk("R12 not done mid sequence", int'(done), 0);

        // R9 abort at the initial stage
        do_reset();
        fail_in = 1'b1; run_all = 1'b1; step = 1'b1;
        @(negedge clk);
        step = 1'b0; fail_in = 1'b0;
        chk("R9 error raised", int'(seq_err), 1);
        chk("R9 stage held at 0", int'(stage_o), 0);
        step = 1'b1;
        repeat (3) @(negedge clk);
        step = 1'b0;
        @(negedge clk);
        chk("R9 later steps ignored", int'(stage_o), 0);
        chk("R9 enables low", outs() + int'(pwm_start) + int'(busy), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule